// File: doc/BRIEF.md
# Memory Bank Chip-Select Decoder

This block splits a 24-bit physical address space into four equal banks and turns each bus access into active-low chip-select, output-enable and write-enable lines and a wait-state count for the bus sequencer. A programmable pair of adjacent address bits gives the bank index. The pair's position sets the bank size. A control byte for each bank then picks one of three chip selects, one of two strobe pairs, whether writes are blocked, and the wait-state count. The control byte can also flip either bank-index bit on the address sent to the memory. That lets a bank show a different slice of a device larger than itself.

Two more controls act on the index before the bank is chosen. Root-segment or data-segment accesses can have the index MSB flipped, which places code and data in separate devices. Extended-window accesses can be forced onto one bank's control byte whatever their address. A mode bit can hold chip select 1 low at all times. A small register port (address, data, write strobe) loads the configuration. All outputs are combinational from the stored configuration and the current access.

Top module: `bank_cs_decoder`

## Requirements
- R1: After reset, bank 0's control byte is 0x08 and banks 1 to 3 hold 0x00. The pair code, override code and mode bits are all zero. A read of bank 0 therefore drives CS0 and OE0 with 4 wait states, and a write to bank 0 asserts no write strobe and reports 5 wait states.
- R2: Register 4 bits [7:5] select the index pair (high bit, low bit). The codes are 000=A19/A18, 001=A20/A19, 010=A21/A20, 011=A22/A21, 100=A23/A22 and 111=A18/A17. The high bit is the index MSB.
- R3: The reserved pair codes 101 and 110 decode as code 000.
- R4: Control bits [7:6] set the read wait states: 00=4, 01=2, 10=1, 11=0. A write takes one more than a read. With no access in progress, the count is 0.
- R5: Control bit 2 picks strobe pair 0 or 1, and control bit 3 set makes the bank read-only. A read drives the chosen OE low. A write drives the chosen WE low unless the bank is read-only. When read and write are both asserted, the access is a write. OE and WE are never low together.
- R6: Control bits [1:0] drive CS0, CS1 or CS2 for an access. Code 11 drives no chip select and raises cfg_err for as long as the access lasts.
- R7: Control bit 5 inverts the index MSB and control bit 4 inverts the index LSB in mem_addr. These two bits do not change which bank is chosen. All other address bits pass through unchanged.
- R8: Register 5 bit 0 flips the index MSB for root-segment accesses, and bit 1 does the same for data-segment accesses. The flip happens before the bank is chosen and also shows in mem_addr.
- R9: When register 4 bits [2:0] are 1bb, an extended-window access uses bank bb's control byte whatever its address bits. The address itself is still translated as usual. Codes 0xx have no effect.
- R10: Register 5 bit 2 holds CS1 low on every cycle, including idle ones. The chip select chosen by the access is still driven as well.
- R11: With neither read nor write asserted, all OE and WE lines are high and cfg_err is low.
- R12: Configuration writes land on the rising clock edge: register addresses 0 to 3 are the bank control bytes, 4 is the pair/override byte and 5 is the mode byte. An access in the same cycle as a write decodes with the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| paddr | input | 24 | Physical address of the access |
| acc_rd | input | 1 | Read access |
| acc_wr | input | 1 | Write access |
| seg_root | input | 1 | Access comes from the root segment |
| seg_data | input | 1 | Access comes from the data segment |
| seg_xwin | input | 1 | Access comes through the extended window |
| cs_n | output | 3 | Active-low chip selects |
| oe_n | output | 2 | Active-low output enables |
| we_n | output | 2 | Active-low write enables |
| wait_states | output | 3 | Wait states for this access |
| mem_addr | output | 24 | Address with the bank-index bits translated |
| cfg_err | output | 1 | Access hit a bank with the reserved chip-select code |

## Verification
A configuration write and an access can fall in the same cycle. The bench provokes this by writing bank 0's control byte while reading bank 0. Outputs are sampled before the edge and again after it. The first sample must show the old wait count and chip select and the second the new ones. The bench also combines a segment flip with an extended-window override, to check that the override wins the bank choice while mem_addr keeps the flipped bits.

// File: rtl/bank_cs_decoder.sv
module bank_cs_decoder #(
  parameter int AW     = 24,
  parameter int NBANK  = 4,
  parameter int NCS    = 3,
  parameter int NSTB   = 2,
  parameter int WSW    = 3,
  parameter int CFG_AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic [AW-1:0]     paddr,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic              seg_root,
  input  logic              seg_data,
  input  logic              seg_xwin,
  output logic [NCS-1:0]    cs_n,
  output logic [NSTB-1:0]   oe_n,
  output logic [NSTB-1:0]   we_n,
  output logic [WSW-1:0]    wait_states,
  output logic [AW-1:0]     mem_addr,
  output logic              cfg_err
);
  localparam int BIW = $clog2(NBANK);
  localparam int PW  = $clog2(AW);
  localparam logic [CFG_AW-1:0] PAIR_REG = CFG_AW'(NBANK);
  localparam logic [CFG_AW-1:0] MODE_REG = CFG_AW'(NBANK + 1);

  logic [7:0] bank_ctl [NBANK];
  logic [2:0] pair_code, ovr_code;
  logic       root_inv, data_inv, force_cs1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANK; b++) bank_ctl[b] <= (b == 0) ? 8'h08 : 8'h00;
      pair_code <= '0;
      ovr_code  <= '0;
      root_inv  <= 1'b0;
      data_inv  <= 1'b0;
      force_cs1 <= 1'b0;
    end else if (cfg_we) begin
      for (int b = 0; b < NBANK; b++)
        if (cfg_addr == CFG_AW'(b)) bank_ctl[b] <= cfg_wdata;
      if (cfg_addr == PAIR_REG) begin
        pair_code <= cfg_wdata[7:5];
        ovr_code  <= cfg_wdata[2:0];
      end
      if (cfg_addr == MODE_REG) begin
        root_inv  <= cfg_wdata[0];
        data_inv  <= cfg_wdata[1];
        force_cs1 <= cfg_wdata[2];
      end
    end
  end

  logic [PW-1:0] hi_pos, lo_pos;
  always_comb begin
    case (pair_code)
      3'b001:  hi_pos = PW'(20);
      3'b010:  hi_pos = PW'(21);
      3'b011:  hi_pos = PW'(22);
      3'b100:  hi_pos = PW'(23);
      3'b111:  hi_pos = PW'(18);
      default: hi_pos = PW'(19);
    endcase
    lo_pos = hi_pos - PW'(1);
  end

  logic [BIW-1:0] raw_idx, seg_idx, bank, out_idx;
  logic [7:0]     ctl;
  logic           seg_flip, active, do_rd;

  assign raw_idx  = {paddr[hi_pos], paddr[lo_pos]};
  assign seg_flip = (seg_root & root_inv) | (seg_data & data_inv);
  assign seg_idx  = raw_idx ^ {seg_flip, 1'b0};
  assign bank     = (seg_xwin && ovr_code[2]) ? ovr_code[BIW-1:0] : seg_idx;
  assign ctl      = bank_ctl[bank];
  assign out_idx  = seg_idx ^ ctl[5:4];
  assign active   = acc_rd | acc_wr;
  assign do_rd    = acc_rd & ~acc_wr;

  always_comb begin
    mem_addr = paddr;
    mem_addr[hi_pos] = out_idx[1];
    mem_addr[lo_pos] = out_idx[0];
  end

  genvar g;
  generate
    for (g = 0; g < NCS; g++) begin : g_cs
      if (g == 1) begin : g_forceable
        assign cs_n[g] = ~((active && ctl[1:0] == 2'(g)) || force_cs1);
      end else begin : g_plain
        assign cs_n[g] = ~(active && ctl[1:0] == 2'(g));
      end
    end
    for (g = 0; g < NSTB; g++) begin : g_stb
      assign oe_n[g] = ~(do_rd && ctl[2] == 1'(g));
      assign we_n[g] = ~(acc_wr && !ctl[3] && ctl[2] == 1'(g));
    end
  endgenerate

  logic [WSW-1:0] rd_ws;
  always_comb begin
    case (ctl[7:6])
      2'b00:   rd_ws = WSW'(4);
      2'b01:   rd_ws = WSW'(2);
      2'b10:   rd_ws = WSW'(1);
      default: rd_ws = WSW'(0);
    endcase
  end

  assign wait_states = !active ? '0 : (rd_ws + WSW'(acc_wr));
  assign cfg_err     = active && ctl[1:0] == 2'b11;

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((~oe_n != '0) && (~we_n != '0)));
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (&oe_n && &we_n && !cfg_err && wait_states == '0));
  // R6
  reserved_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !force_cs1) |-> &cs_n);
  // R6
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !force_cs1 |-> $onehot0(~cs_n));
  // R10
  force_cs1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_cs1 |-> !cs_n[1]);
  // R4
  wait_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_states <= WSW'(5));
  // R12
  cfg_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == PAIR_REG) |=> (pair_code == $past(cfg_wdata[7:5])));
endmodule

// File: tb/test_bank_cs_decoder.sv
module test_bank_cs_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [23:0] paddr = '0;
  logic        acc_rd = 1'b0, acc_wr = 1'b0;
  logic        seg_root = 1'b0, seg_data = 1'b0, seg_xwin = 1'b0;
  logic [2:0]  cs_n;
  logic [1:0]  oe_n, we_n;
  logic [2:0]  wait_states;
  logic [23:0] mem_addr;
  logic        cfg_err;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  bank_cs_decoder i_bank_cs_decoder (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .paddr, .acc_rd, .acc_wr,
    .seg_root, .seg_data, .seg_xwin, .cs_n, .oe_n, .we_n, .wait_states,
    .mem_addr, .cfg_err);

  // addr, rd, wr, cs_n, oe_n, we_n, ws, mem_addr, err
  localparam logic [60:0] VEC [9] = '{
    {24'h012345, 1'b1, 1'b0, 3'b110, 2'b10, 2'b11, 3'd0, 24'h012345, 1'b0},
    {24'h012345, 1'b0, 1'b1, 3'b110, 2'b11, 2'b10, 3'd1, 24'h012345, 1'b0},
    {24'h054321, 1'b1, 1'b0, 3'b101, 2'b01, 2'b11, 3'd1, 24'h0D4321, 1'b0},
    {24'h054321, 1'b0, 1'b1, 3'b101, 2'b11, 2'b01, 3'd2, 24'h0D4321, 1'b0},
    {24'h0ABCDE, 1'b1, 1'b0, 3'b011, 2'b10, 2'b11, 3'd2, 24'h0EBCDE, 1'b0},
    {24'h0ABCDE, 1'b0, 1'b1, 3'b011, 2'b11, 2'b11, 3'd3, 24'h0EBCDE, 1'b0},
    {24'h3C0000, 1'b1, 1'b0, 3'b111, 2'b01, 2'b11, 3'd4, 24'h300000, 1'b1},
    {24'h3C0000, 1'b0, 1'b1, 3'b111, 2'b11, 2'b11, 3'd5, 24'h300000, 1'b1},
    {24'h054321, 1'b0, 1'b0, 3'b111, 2'b11, 2'b11, 3'd0, 24'h0D4321, 1'b0}
  };

  task automatic chk(input string req, input logic [2:0] ecs, input logic [1:0] eoe,
                     input logic [1:0] ewe, input logic [2:0] ews,
                     input logic [23:0] ea, input logic eerr);
    checks++;
    if ({cs_n, oe_n, we_n, wait_states, mem_addr, cfg_err} !== {ecs, eoe, ewe, ews, ea, eerr}) begin
      fails++;
      $display("FAIL %s: got cs_n=%b oe_n=%b we_n=%b ws=%0d addr=%h err=%b, expected cs_n=%b oe_n=%b we_n=%b ws=%0d addr=%h err=%b",
               req, cs_n, oe_n, we_n, wait_states, mem_addr, cfg_err, ecs, eoe, ewe, ews, ea, eerr);
    end
  endtask

  task automatic acc(input logic [23:0] a, input logic rd, input logic wr,
                     input logic rt, input logic dt, input logic xw);
    @(negedge clk);
    paddr = a; acc_rd = rd; acc_wr = wr; seg_root = rt; seg_data = dt; seg_xwin = xw;
    #1;
  endtask

  task automatic wcfg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    acc_rd = 1'b0; acc_wr = 1'b0;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    acc(24'h000000, 1, 0, 0, 0, 0); chk("R1 bank0 read",  3'b110, 2'b10, 2'b11, 3'd4, 24'h000000, 0);
    acc(24'h000000, 0, 1, 0, 0, 0); chk("R1 bank0 write", 3'b110, 2'b11, 2'b11, 3'd5, 24'h000000, 0);
    acc(24'h040000, 0, 1, 0, 0, 0); chk("R1 bank1 write", 3'b110, 2'b11, 2'b10, 3'd5, 24'h040000, 0);
    acc(24'h000000, 0, 0, 0, 0, 0); chk("R11 idle after reset", 3'b111, 2'b11, 2'b11, 3'd0, 24'h000000, 0);

    // R4 R5 R6 R7 R11 vector walk
    wcfg(3'd0, 8'hC0); wcfg(3'd1, 8'hA5); wcfg(3'd2, 8'h5A); wcfg(3'd3, 8'h3F);
    for (int i = 0; i < 9; i++) begin
      acc(VEC[i][60:37], VEC[i][36], VEC[i][35], 0, 0, 0);
      chk($sformatf("R4/R5/R6/R7/R11 vector %0d", i), VEC[i][34:32], VEC[i][31:30],
          VEC[i][29:28], VEC[i][27:25], VEC[i][24:1], VEC[i][0]);
    end

    // R2 R3 pair selection
    wcfg(3'd0, 8'hC0); wcfg(3'd1, 8'h81); wcfg(3'd2, 8'h42); wcfg(3'd3, 8'h00);
    for (int c = 0; c < 8; c++) begin
      int hi;
      hi = (c == 7) ? 18 : (c >= 5) ? 19 : 19 + c;
      wcfg(3'd4, {3'(c), 5'b0});
      acc(24'h1 << hi, 1, 0, 0, 0, 0);
      chk($sformatf("R2/R3 code %0d msb", c), 3'b011, 2'b10, 2'b11, 3'd2, 24'h1 << hi, 0);
      acc(24'h1 << (hi - 1), 1, 0, 0, 0, 0);
      chk($sformatf("R2/R3 code %0d lsb", c), 3'b101, 2'b10, 2'b11, 3'd1, 24'h1 << (hi - 1), 0);
      if (c == 5 || c == 6) begin
        acc(24'h800000, 1, 0, 0, 0, 0);
        chk($sformatf("R3 code %0d A23 ignored", c), 3'b110, 2'b10, 2'b11, 3'd0, 24'h800000, 0);
      end
    end
    wcfg(3'd4, 8'h00);

    // R8 segment flips
    wcfg(3'd5, 8'h01);
    acc(24'h000100, 1, 0, 1, 0, 0); chk("R8 root flip",    3'b011, 2'b10, 2'b11, 3'd2, 24'h080100, 0);
    acc(24'h000100, 1, 0, 0, 1, 0); chk("R8 data no flip", 3'b110, 2'b10, 2'b11, 3'd0, 24'h000100, 0);
    wcfg(3'd5, 8'h02);
    acc(24'h000100, 1, 0, 0, 1, 0); chk("R8 data flip",    3'b011, 2'b10, 2'b11, 3'd2, 24'h080100, 0);
    acc(24'h000100, 1, 0, 1, 0, 0); chk("R8 root no flip", 3'b110, 2'b10, 2'b11, 3'd0, 24'h000100, 0);

    // R9 override, also combined with a segment flip
    wcfg(3'd4, 8'h07);
    acc(24'h000100, 1, 0, 0, 1, 1); chk("R9 override beats flip", 3'b110, 2'b10, 2'b11, 3'd4, 24'h080100, 0);
    wcfg(3'd5, 8'h00);
    acc(24'h040010, 1, 0, 0, 0, 1); chk("R9 xwin forced bank3", 3'b110, 2'b10, 2'b11, 3'd4, 24'h040010, 0);
    acc(24'h040010, 1, 0, 0, 0, 0); chk("R9 non-xwin by addr",  3'b101, 2'b10, 2'b11, 3'd1, 24'h040010, 0);
    wcfg(3'd4, 8'h03);
    acc(24'h040010, 1, 0, 0, 0, 1); chk("R9 override off",      3'b101, 2'b10, 2'b11, 3'd1, 24'h040010, 0);
    wcfg(3'd4, 8'h00);

    // R10 forced CS1
    wcfg(3'd5, 8'h04);
    acc(24'h080000, 0, 0, 0, 0, 0); chk("R10 idle cs1 held", 3'b101, 2'b11, 2'b11, 3'd0, 24'h080000, 0);
    acc(24'h080000, 1, 0, 0, 0, 0); chk("R10 cs2 plus cs1",  3'b001, 2'b10, 2'b11, 3'd2, 24'h080000, 0);
    wcfg(3'd5, 8'h00);

    // R5 read and write together counts as write
    acc(24'h040000, 1, 1, 0, 0, 0); chk("R5 rd+wr is write", 3'b101, 2'b11, 2'b10, 3'd2, 24'h040000, 0);

    // R12 write and access in the same cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 8'h81;
    paddr = 24'h000000; acc_rd = 1'b1; acc_wr = 1'b0; seg_root = 0; seg_data = 0; seg_xwin = 0;
    #1 chk("R12 old config before edge", 3'b110, 2'b10, 2'b11, 3'd0, 24'h000000, 0);
    @(posedge clk); #1;
    cfg_we = 1'b0;
    chk("R12 new config after edge", 3'b101, 2'b10, 2'b11, 3'd1, 24'h000000, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule